// File: doc/BRIEF.md
# Hashed MAC Learning Table with Aging

This block keeps the station table of a small three-port Ethernet switch. It has 2048 records of 64 bits, organised as 256 slots of 8 ways. The slot of a MAC address is the XOR of its six bytes. Learn requests record which port a source address was last seen on. Lookup requests turn a destination address into an egress port mask. A host port writes static records, which hold a fixed port mask and a priority.

A prescaled 10-bit time counter wraps modulo 1024. Each time it steps, a background sweep starts and visits every record, one per clock. The sweep invalidates any dynamic record whose age is above a programmable limit. Age is the current time minus the stored timestamp, modulo 1024. Only one action touches the table in each cycle. A lookup always wins. A host write beats a learn, and a learn beats a sweep step.

Record layout, with bit numbers counted over the whole 64-bit record:

| Bits | All records | Dynamic records | Static records |
|------|-------------|-----------------|----------------|
| 47:0 | MAC address | | |
| 48 | valid | | |
| 49 | type (1 = static) | | |
| 59:50 | | timestamp | |
| 63:60 | | port number | |
| 52:50 | | | priority |
| 55:53 | | | port mask |

Top module: `mac_learn_table`

## Requirements
- R1: After reset the table is empty, `lkp_vld` is 0, `cur_time` is 0 and both grants are 0. A lookup of any address then misses.
- R2: A lookup raised before a clock edge gives `lkp_vld` = 1 right after that edge. The result is held until the next lookup. On a miss, `lkp_hit` = 0 and `lkp_mask` has every port bit set except the ingress port (port p is mask bit p).
- R3: A granted learn of an unknown address installs a dynamic record. A later lookup returns `lkp_hit` = 1, `lkp_static` = 0, the learned port as a one-hot mask and priority 0.
- R4: Learning an address that already has a dynamic record rewrites that record's port and timestamp in place.
- R5: A learn that finds no match takes the first invalid way of its slot. If the slot is full, it replaces the dynamic record with the largest age, choosing the lowest way on a tie. A static record is never replaced, so a learn into a slot of eight static records is dropped.
- R6: A host write stores at `hst_idx` a static record built from `hst_mac`, `hst_mask`, `hst_prio` and `hst_valid`. A lookup hit on it returns that mask and priority with `lkp_static` = 1. A learn of the same address leaves it unchanged.
- R7: The table has one user per cycle, in the priority order lookup, host write, learn, sweep step. `hst_gnt` is `hst_req` with no lookup. `lrn_gnt` is `lrn_req` with neither a lookup nor a host write. A request that is not granted waits.
- R8: `cur_time` steps by one, modulo 1024, once every TICK_CYCLES clocks (4096 by default).
- R9: A sweep starts on each time step. It clears every valid dynamic record for which (`cur_time` − timestamp) mod 1024 > `age_limit`. Records at or below the limit, and all static records, are kept.
- R10: A lookup or learn of an address only searches the records at indices hash×8 to hash×8+7, where hash is the XOR of the six address bytes. A record placed in any other slot is never found.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| age_limit | input | 10 | Largest age a dynamic record may have and still survive a sweep |
| lkp_req | input | 1 | Lookup request |
| lkp_mac | input | 48 | Destination address to look up |
| lkp_in_port | input | 2 | Ingress port of the frame being looked up |
| lkp_vld | output | 1 | Lookup result valid (one cycle after the request) |
| lkp_hit | output | 1 | Lookup found a record |
| lkp_static | output | 1 | The record found is static |
| lkp_mask | output | 3 | Egress port mask |
| lkp_prio | output | 3 | Priority of the record found (0 for dynamic records and misses) |
| lrn_req | input | 1 | Learn request, held until granted |
| lrn_mac | input | 48 | Source address to learn |
| lrn_port | input | 2 | Port the source address was seen on |
| lrn_gnt | output | 1 | Learn is performed at this clock edge |
| hst_req | input | 1 | Host static-record write request, held until granted |
| hst_idx | input | 11 | Table index to write |
| hst_valid | input | 1 | Valid flag of the written record |
| hst_mac | input | 48 | Address of the written record |
| hst_mask | input | 3 | Port mask of the written record |
| hst_prio | input | 3 | Priority of the written record |
| hst_gnt | output | 1 | Host write is performed at this clock edge |
| cur_time | output | 10 | Current value of the aging time counter |

## Verification
The key overlap is a lookup, a host write and a learn all raised on the same clock edge, while the aging sweep competes in the background. The bench raises all three requests together. It checks that only the lookup is answered in the first cycle. It then checks that the grants go to the host write and then to the learn on the next two edges. Later lookups show that both delayed writes reached the table. Sweep steps that are stalled behind requests are judged by whether stale dynamic records are gone, and static and fresh records are still present, once a full sweep length has passed after a time step.

// File: rtl/mlt_pkg.sv
package mlt_pkg;
  localparam int MAC_W      = 48;
  localparam int ENT_W      = 64;
  localparam int TS_W       = 10;
  localparam int PFLD_W     = 4;
  localparam int NPORTS     = 3;
  localparam int PRIO_W     = 3;
  localparam int HASH_W     = 8;
  // record field positions (whole 64-bit record)
  localparam int VALID_B    = 48;
  localparam int STAT_B     = 49;
  localparam int TS_LSB     = 50;
  localparam int PORT_LSB   = 60;
  localparam int PRIO_LSB   = 50;
  localparam int MASK_LSB   = 53;

  typedef logic [ENT_W-1:0] entry_t;

  function automatic logic ent_valid(input entry_t e);
    return e[VALID_B];
  endfunction

  function automatic logic ent_static(input entry_t e);
    return e[STAT_B];
  endfunction

  function automatic logic [MAC_W-1:0] ent_mac(input entry_t e);
    return e[MAC_W-1:0];
  endfunction

  function automatic logic [TS_W-1:0] ent_ts(input entry_t e);
    return e[TS_LSB +: TS_W];
  endfunction

  function automatic logic [PFLD_W-1:0] ent_port(input entry_t e);
    return e[PORT_LSB +: PFLD_W];
  endfunction

  function automatic logic [NPORTS-1:0] ent_mask(input entry_t e);
    return e[MASK_LSB +: NPORTS];
  endfunction

  function automatic logic [PRIO_W-1:0] ent_prio(input entry_t e);
    return e[PRIO_LSB +: PRIO_W];
  endfunction

  function automatic entry_t mk_dyn(input logic [MAC_W-1:0] mac,
                                    input logic [PFLD_W-1:0] port,
                                    input logic [TS_W-1:0] ts);
    entry_t e;
    e = '0;
    e[MAC_W-1:0]           = mac;
    e[VALID_B]             = 1'b1;
    e[STAT_B]              = 1'b0;
    e[TS_LSB +: TS_W]      = ts;
    e[PORT_LSB +: PFLD_W]  = port;
    return e;
  endfunction

  function automatic entry_t mk_stat(input logic [MAC_W-1:0] mac,
                                     input logic [NPORTS-1:0] mask,
                                     input logic [PRIO_W-1:0] prio,
                                     input logic valid);
    entry_t e;
    e = '0;
    e[MAC_W-1:0]           = mac;
    e[VALID_B]             = valid;
    e[STAT_B]              = 1'b1;
    e[PRIO_LSB +: PRIO_W]  = prio;
    e[MASK_LSB +: NPORTS]  = mask;
    return e;
  endfunction

  function automatic logic [HASH_W-1:0] mac_hash(input logic [MAC_W-1:0] mac);
    logic [HASH_W-1:0] h;
    h = '0;
    for (int b = 0; b < MAC_W / 8; b++) h = h ^ mac[b*8 +: 8];
    return h;
  endfunction

  function automatic logic [TS_W-1:0] ts_age(input logic [TS_W-1:0] now,
                                             input logic [TS_W-1:0] then_ts);
    return now - then_ts;
  endfunction

  function automatic logic [NPORTS-1:0] port_onehot(input logic [PFLD_W-1:0] p);
    logic [NPORTS-1:0] r;
    r = '0;
    for (int i = 0; i < NPORTS; i++) if (p == PFLD_W'(i)) r[i] = 1'b1;
    return r;
  endfunction
endpackage

// File: rtl/mlt_time_base.sv
module mlt_time_base #(
  parameter int TICK_CYCLES = 4096,
  parameter int TS_W        = 10
) (
  input  logic            clk,
  input  logic            rst_n,
  output logic            tick,
  output logic [TS_W-1:0] cur_time
);
  localparam int PRE_W = (TICK_CYCLES > 1) ? $clog2(TICK_CYCLES) : 1;
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(TICK_CYCLES - 1);

  logic [PRE_W-1:0] pre;

  assign tick = (pre == PRE_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre      <= '0;
      cur_time <= '0;
    end else if (tick) begin
      pre      <= '0;
      cur_time <= cur_time + 1'b1;
    end else begin
      pre      <= pre + 1'b1;
    end
  end

  // R8
  time_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> (cur_time == TS_W'($past(cur_time) + 1'b1)));

  // R8
  time_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(cur_time));
endmodule

// File: rtl/mlt_way_select.sv
module mlt_way_select
  import mlt_pkg::*;
#(
  parameter int WAYS     = 8,
  parameter int WAY_BITS = 3
) (
  input  entry_t [WAYS-1:0]     ents,
  input  logic [MAC_W-1:0]      key,
  input  logic [TS_W-1:0]       now,
  output logic                  hit,
  output logic                  hit_static,
  output logic [WAY_BITS-1:0]   hit_way,
  output logic                  has_free,
  output logic [WAY_BITS-1:0]   free_way,
  output logic                  has_victim,
  output logic [WAY_BITS-1:0]   victim_way
);
  logic [TS_W-1:0] best_age;

  always_comb begin
    hit        = 1'b0;
    hit_static = 1'b0;
    hit_way    = '0;
    has_free   = 1'b0;
    free_way   = '0;
    has_victim = 1'b0;
    victim_way = '0;
    best_age   = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (!hit && ent_valid(ents[w]) && (ent_mac(ents[w]) == key)) begin
        hit        = 1'b1;
        hit_static = ent_static(ents[w]);
        hit_way    = WAY_BITS'(w);
      end
      if (!has_free && !ent_valid(ents[w])) begin
        has_free = 1'b1;
        free_way = WAY_BITS'(w);
      end
      if (ent_valid(ents[w]) && !ent_static(ents[w]) &&
          (!has_victim || (ts_age(now, ent_ts(ents[w])) > best_age))) begin
        has_victim = 1'b1;
        victim_way = WAY_BITS'(w);
        best_age   = ts_age(now, ent_ts(ents[w]));
      end
    end
  end
endmodule

// File: rtl/mlt_arbiter.sv
module mlt_arbiter (
  input  logic clk,
  input  logic rst_n,
  input  logic lkp_req,
  input  logic hst_req,
  input  logic lrn_req,
  input  logic age_req,
  output logic g_hst,
  output logic g_lrn,
  output logic g_age
);
  assign g_hst = hst_req & ~lkp_req;
  assign g_lrn = lrn_req & ~lkp_req & ~hst_req;
  assign g_age = age_req & ~lkp_req & ~hst_req & ~lrn_req;

  // R7
  one_user_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({lkp_req, g_hst, g_lrn, g_age}));

  // R7
  age_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (age_req && !g_age) |=> age_req);
endmodule

// File: rtl/mac_learn_table.sv
module mac_learn_table
  import mlt_pkg::*;
#(
  parameter int SLOT_BITS   = 8,
  parameter int WAY_BITS    = 3,
  parameter int TICK_CYCLES = 4096
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [9:0]               age_limit,
  input  logic                     lkp_req,
  input  logic [47:0]              lkp_mac,
  input  logic [1:0]               lkp_in_port,
  output logic                     lkp_vld,
  output logic                     lkp_hit,
  output logic                     lkp_static,
  output logic [2:0]               lkp_mask,
  output logic [2:0]               lkp_prio,
  input  logic                     lrn_req,
  input  logic [47:0]              lrn_mac,
  input  logic [1:0]               lrn_port,
  output logic                     lrn_gnt,
  input  logic                     hst_req,
  input  logic [SLOT_BITS+WAY_BITS-1:0] hst_idx,
  input  logic                     hst_valid,
  input  logic [47:0]              hst_mac,
  input  logic [2:0]               hst_mask,
  input  logic [2:0]               hst_prio,
  output logic                     hst_gnt,
  output logic [9:0]               cur_time
);
  localparam int WAYS  = 1 << WAY_BITS;
  localparam int IDX_W = SLOT_BITS + WAY_BITS;
  localparam int N_ENT = 1 << IDX_W;
  localparam logic [NPORTS-1:0] ALL_PORTS = '1;

  entry_t tbl [N_ENT];

  // time base and sweep start
  logic time_tick;
  mlt_time_base #(.TICK_CYCLES(TICK_CYCLES), .TS_W(TS_W)) u_time (
    .clk(clk), .rst_n(rst_n), .tick(time_tick), .cur_time(cur_time)
  );

  // arbitration
  logic age_act;
  logic g_hst, g_lrn, g_age;
  mlt_arbiter u_arb (
    .clk(clk), .rst_n(rst_n), .lkp_req(lkp_req), .hst_req(hst_req),
    .lrn_req(lrn_req), .age_req(age_act),
    .g_hst(g_hst), .g_lrn(g_lrn), .g_age(g_age)
  );
  assign hst_gnt = g_hst;
  assign lrn_gnt = g_lrn;

  // slot reads for lookup and learn
  logic [HASH_W-1:0]    lk_hash, lr_hash;
  logic [SLOT_BITS-1:0] lk_slot, lr_slot;
  entry_t [WAYS-1:0]    lk_ents, lr_ents;

  assign lk_hash = mac_hash(lkp_mac);
  assign lr_hash = mac_hash(lrn_mac);
  assign lk_slot = SLOT_BITS'(lk_hash);
  assign lr_slot = SLOT_BITS'(lr_hash);

  for (genvar g = 0; g < WAYS; g++) begin : g_rd
    assign lk_ents[g] = tbl[{lk_slot, WAY_BITS'(g)}];
    assign lr_ents[g] = tbl[{lr_slot, WAY_BITS'(g)}];
  end

  logic                lk_hit, lk_hit_st, lk_free, lk_vict;
  logic [WAY_BITS-1:0] lk_way, lk_free_way, lk_vict_way;
  mlt_way_select #(.WAYS(WAYS), .WAY_BITS(WAY_BITS)) u_lk_sel (
    .ents(lk_ents), .key(lkp_mac), .now(cur_time),
    .hit(lk_hit), .hit_static(lk_hit_st), .hit_way(lk_way),
    .has_free(lk_free), .free_way(lk_free_way),
    .has_victim(lk_vict), .victim_way(lk_vict_way)
  );

  logic                lr_hit, lr_hit_st, lr_free, lr_vict;
  logic [WAY_BITS-1:0] lr_way, lr_free_way, lr_vict_way;
  mlt_way_select #(.WAYS(WAYS), .WAY_BITS(WAY_BITS)) u_lr_sel (
    .ents(lr_ents), .key(lrn_mac), .now(cur_time),
    .hit(lr_hit), .hit_static(lr_hit_st), .hit_way(lr_way),
    .has_free(lr_free), .free_way(lr_free_way),
    .has_victim(lr_vict), .victim_way(lr_vict_way)
  );

  // lookup result
  entry_t            lk_ent;
  logic [NPORTS-1:0] lk_mask_c;
  logic [PRIO_W-1:0] lk_prio_c;

  assign lk_ent = lk_ents[lk_way];

  always_comb begin
    lk_prio_c = '0;
    if (lk_hit && lk_hit_st) begin
      lk_mask_c = ent_mask(lk_ent);
      lk_prio_c = ent_prio(lk_ent);
    end else if (lk_hit) begin
      lk_mask_c = port_onehot(ent_port(lk_ent));
    end else begin
      lk_mask_c = ALL_PORTS & ~port_onehot({2'b00, lkp_in_port});
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lkp_vld    <= 1'b0;
      lkp_hit    <= 1'b0;
      lkp_static <= 1'b0;
      lkp_mask   <= '0;
      lkp_prio   <= '0;
    end else begin
      lkp_vld <= lkp_req;
      if (lkp_req) begin
        lkp_hit    <= lk_hit;
        lkp_static <= lk_hit & lk_hit_st;
        lkp_mask   <= lk_mask_c;
        lkp_prio   <= lk_prio_c;
      end
    end
  end

  // learn decision
  logic                lrn_wr;
  logic [WAY_BITS-1:0] lrn_way;
  entry_t              lrn_ent;

  assign lrn_wr  = g_lrn & (lr_hit ? ~lr_hit_st : (lr_free | lr_vict));
  assign lrn_way = lr_hit ? lr_way : (lr_free ? lr_free_way : lr_vict_way);
  assign lrn_ent = mk_dyn(lrn_mac, {2'b00, lrn_port}, cur_time);

  // aging sweep
  logic [IDX_W-1:0] age_idx;
  entry_t           age_ent;
  logic             age_clr;

  assign age_ent = tbl[age_idx];
  assign age_clr = g_age & ent_valid(age_ent) & ~ent_static(age_ent) &
                   (ts_age(cur_time, ent_ts(age_ent)) > age_limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      age_act <= 1'b0;
      age_idx <= '0;
    end else if (!age_act) begin
      if (time_tick) begin
        age_act <= 1'b1;
        age_idx <= '0;
      end
    end else if (g_age) begin
      age_idx <= age_idx + 1'b1;
      if (age_idx == IDX_W'(N_ENT - 1)) age_act <= 1'b0;
    end
  end

  // single write port
  logic       wr_en;
  logic [IDX_W-1:0] wr_idx;
  entry_t     wr_data;

  always_comb begin
    wr_en   = 1'b0;
    wr_idx  = '0;
    wr_data = '0;
    if (g_hst) begin
      wr_en   = 1'b1;
      wr_idx  = hst_idx;
      wr_data = mk_stat(hst_mac, hst_mask, hst_prio, hst_valid);
    end else if (lrn_wr) begin
      wr_en   = 1'b1;
      wr_idx  = {lr_slot, lrn_way};
      wr_data = lrn_ent;
    end else if (age_clr) begin
      wr_en   = 1'b1;
      wr_idx  = age_idx;
      wr_data = age_ent;
      wr_data[VALID_B] = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < N_ENT; i++) tbl[i] <= '0;
    end else if (wr_en) begin
      tbl[wr_idx] <= wr_data;
    end
  end

  // R2
  lkp_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lkp_req |=> lkp_vld);

  // R2
  flood_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lkp_vld && $past(lkp_req) && !lkp_hit) |->
      ((lkp_mask & port_onehot({2'b00, $past(lkp_in_port)})) == '0));

  // R5
  static_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lrn_wr |-> !(ent_valid(tbl[wr_idx]) && ent_static(tbl[wr_idx])));

  // R9
  age_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
    age_clr |-> (ent_valid(tbl[age_idx]) && !ent_static(tbl[age_idx])));

  // R9
  age_gone_chk: assert property (@(posedge clk) disable iff (!rst_n)
    age_clr |=> !ent_valid(tbl[$past(age_idx)]));

  // R3
  learn_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lrn_wr |=> ent_valid(tbl[$past(wr_idx)]) && !ent_static(tbl[$past(wr_idx)]));
endmodule

// File: tb/mac_learn_table_tb_top.sv
module mac_learn_table_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [9:0]  age_limit;
  logic        lkp_req;
  logic [47:0] lkp_mac;
  logic [1:0]  lkp_in_port;
  logic        lkp_vld, lkp_hit, lkp_static;
  logic [2:0]  lkp_mask, lkp_prio;
  logic        lrn_req;
  logic [47:0] lrn_mac;
  logic [1:0]  lrn_port;
  logic        lrn_gnt;
  logic        hst_req;
  logic [10:0] hst_idx;
  logic        hst_valid;
  logic [47:0] hst_mac;
  logic [2:0]  hst_mask, hst_prio;
  logic        hst_gnt;
  logic [9:0]  cur_time;

  int n_chk  = 0;
  int n_fail = 0;
  localparam int TICK = 4096;

  always #4 clk = ~clk;

  mac_learn_table dut_i (
    .clk(clk), .rst_n(rst_n), .age_limit(age_limit),
    .lkp_req(lkp_req), .lkp_mac(lkp_mac), .lkp_in_port(lkp_in_port),
    .lkp_vld(lkp_vld), .lkp_hit(lkp_hit), .lkp_static(lkp_static),
    .lkp_mask(lkp_mask), .lkp_prio(lkp_prio),
    .lrn_req(lrn_req), .lrn_mac(lrn_mac), .lrn_port(lrn_port), .lrn_gnt(lrn_gnt),
    .hst_req(hst_req), .hst_idx(hst_idx), .hst_valid(hst_valid), .hst_mac(hst_mac),
    .hst_mask(hst_mask), .hst_prio(hst_prio), .hst_gnt(hst_gnt),
    .cur_time(cur_time)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] bhash(input logic [47:0] m);
    logic [7:0] h = 8'h00;
    for (int i = 0; i < 6; i++) h = h ^ m[8*i +: 8];
    return h;
  endfunction

  function automatic logic [47:0] mac_in(input logic [7:0] h, input logic [39:0] b);
    logic [47:0] m;
    m = {b, 8'h00};
    m[7:0] = h ^ bhash(m);
    return m;
  endfunction

  task automatic lookup(input logic [47:0] m, input logic [1:0] inp,
                        output logic hit, output logic st,
                        output logic [2:0] mask, output logic [2:0] prio);
    @(negedge clk);
    lkp_req = 1'b1; lkp_mac = m; lkp_in_port = inp;
    @(negedge clk);
    hit = lkp_hit; st = lkp_static; mask = lkp_mask; prio = lkp_prio;
    lkp_req = 1'b0;
  endtask

  task automatic learn(input logic [47:0] m, input logic [1:0] p);
    @(negedge clk);
    lrn_req = 1'b1; lrn_mac = m; lrn_port = p;
    #1;
    while (!lrn_gnt) begin @(negedge clk); #1; end
    @(negedge clk);
    lrn_req = 1'b0;
  endtask

  task automatic host_wr(input logic [10:0] idx, input logic v, input logic [47:0] m,
                         input logic [2:0] mask, input logic [2:0] prio);
    @(negedge clk);
    hst_req = 1'b1; hst_idx = idx; hst_valid = v; hst_mac = m;
    hst_mask = mask; hst_prio = prio;
    #1;
    while (!hst_gnt) begin @(negedge clk); #1; end
    @(negedge clk);
    hst_req = 1'b0;
  endtask

  task automatic wait_step();
    logic [9:0] t0;
    t0 = cur_time;
    while (cur_time == t0) @(negedge clk);
  endtask

  // expect a lookup result: hit, static flag, mask, prio
  task automatic expect_lkp(input string tag, input logic [47:0] m, input logic [1:0] inp,
                            input logic eh, input logic es, input logic [2:0] em,
                            input logic [2:0] ep);
    logic h, s; logic [2:0] mk, pr;
    lookup(m, inp, h, s, mk, pr);
    chk(tag, {h, s, mk, pr}, {eh, es, em, ep});
  endtask

  task automatic t_reset();
    chk("R1 lkp_vld after reset", lkp_vld, 0);
    chk("R1 cur_time after reset", cur_time, 0);
    chk("R1 grants after reset", {lrn_gnt, hst_gnt}, 0);
    expect_lkp("R1 empty table miss", 48'h0123456789AB, 2'd0, 0, 0, 3'b110, 0);
  endtask

  task automatic t_latency();
    @(negedge clk);
    lkp_req = 1'b1; lkp_mac = 48'hDEADBEEF0001; lkp_in_port = 2'd1;
    #1;
    chk("R2 no response before edge", lkp_vld, 0);
    @(negedge clk);
    chk("R2 response after one edge", {lkp_vld, lkp_hit, lkp_mask}, {1'b1, 1'b0, 3'b101});
    lkp_req = 1'b0;
    @(negedge clk);
    chk("R2 valid drops", lkp_vld, 0);
    chk("R2 result held", lkp_mask, 3'b101);
    expect_lkp("R2 flood from port 2", 48'hDEADBEEF0002, 2'd2, 0, 0, 3'b011, 0);
  endtask

  task automatic t_learn_move();
    logic [47:0] a;
    a = mac_in(8'h12, 40'h0100000007);
    learn(a, 2'd2);
    expect_lkp("R3 learned dynamic", a, 2'd0, 1, 0, 3'b100, 0);
    learn(a, 2'd1);
    expect_lkp("R4 station move", a, 2'd0, 1, 0, 3'b010, 0);
  endtask

  task automatic t_static();
    logic [47:0] s, w;
    s = mac_in(8'h21, 40'h0A00000001);
    host_wr({8'h21, 3'd3}, 1'b1, s, 3'b101, 3'd6);
    expect_lkp("R6 static hit", s, 2'd0, 1, 1, 3'b101, 3'd6);
    learn(s, 2'd1);
    expect_lkp("R6 learn leaves static", s, 2'd0, 1, 1, 3'b101, 3'd6);
    w = mac_in(8'h30, 40'h0B00000002);
    host_wr({8'h31, 3'd0}, 1'b1, w, 3'b001, 3'd1);
    expect_lkp("R10 wrong slot not found", w, 2'd1, 0, 0, 3'b101, 0);
    host_wr({8'h30, 3'd7}, 1'b1, w, 3'b001, 3'd1);
    expect_lkp("R10 own slot way 7 found", w, 2'd1, 1, 1, 3'b001, 3'd1);
  endtask

  task automatic t_full_static();
    logic [47:0] n;
    for (int i = 0; i < 8; i++)
      host_wr({8'h40, 3'(i)}, 1'b1, mac_in(8'h40, 40'h0C00000000 + 40'(i)), 3'b010, 3'd1);
    n = mac_in(8'h40, 40'h0C000000FF);
    learn(n, 2'd2);
    expect_lkp("R5 learn dropped in static slot", n, 2'd2, 0, 0, 3'b011, 0);
    expect_lkp("R5 static survives learn", mac_in(8'h40, 40'h0C00000005), 2'd0, 1, 1, 3'b010, 3'd1);
  endtask

  task automatic t_replace();
    wait_step();
    learn(mac_in(8'h55, 40'h0D00000000), 2'd0);
    wait_step();
    for (int i = 1; i < 8; i++) learn(mac_in(8'h55, 40'h0D00000000 + 40'(i)), 2'd1);
    learn(mac_in(8'h55, 40'h0D00000100), 2'd2);
    expect_lkp("R5 oldest dynamic evicted", mac_in(8'h55, 40'h0D00000000), 2'd1, 0, 0, 3'b101, 0);
    expect_lkp("R5 new entry installed", mac_in(8'h55, 40'h0D00000100), 2'd0, 1, 0, 3'b100, 0);
    expect_lkp("R5 younger entry kept", mac_in(8'h55, 40'h0D00000003), 2'd0, 1, 0, 3'b010, 0);
  endtask

  task automatic t_collide();
    logic [47:0] c, x, a;
    a = mac_in(8'h12, 40'h0100000007);
    c = mac_in(8'h66, 40'h0E00000001);
    x = mac_in(8'h67, 40'h0E00000002);
    @(negedge clk);
    lkp_req = 1'b1; lkp_mac = a; lkp_in_port = 2'd0;
    hst_req = 1'b1; hst_idx = {8'h67, 3'd0}; hst_valid = 1'b1; hst_mac = x;
    hst_mask = 3'b001; hst_prio = 3'd2;
    lrn_req = 1'b1; lrn_mac = c; lrn_port = 2'd0;
    #1;
    chk("R7 lookup blocks host and learn", {hst_gnt, lrn_gnt}, 2'b00);
    @(negedge clk);
    chk("R7 lookup served first", {lkp_vld, lkp_hit, lkp_mask}, {1'b1, 1'b1, 3'b010});
    lkp_req = 1'b0;
    #1;
    chk("R7 host before learn", {hst_gnt, lrn_gnt}, 2'b10);
    @(negedge clk);
    hst_req = 1'b0;
    #1;
    chk("R7 learn after host", lrn_gnt, 1);
    @(negedge clk);
    lrn_req = 1'b0;
    expect_lkp("R7 delayed learn landed", c, 2'd1, 1, 0, 3'b001, 0);
    expect_lkp("R7 delayed host write landed", x, 2'd1, 1, 1, 3'b001, 3'd2);
  endtask

  task automatic t_time();
    logic [9:0] t0;
    int n;
    wait_step();
    t0 = cur_time;
    n = 0;
    while (cur_time == t0) begin @(negedge clk); n++; end
    chk("R8 step period", n, TICK);
    chk("R8 step by one", cur_time, 10'(t0 + 10'd1));
  endtask

  task automatic t_age();
    logic [47:0] a;
    logic [9:0]  t;
    a = mac_in(8'h77, 40'h0F00000001);
    age_limit = 10'd1;
    wait_step();
    t = cur_time;
    learn(a, 2'd2);
    while (cur_time != 10'(t + 10'd1)) @(negedge clk);
    repeat (2200) @(negedge clk);
    expect_lkp("R9 age at limit kept", a, 2'd0, 1, 0, 3'b100, 0);
    while (cur_time != 10'(t + 10'd2)) @(negedge clk);
    repeat (2200) @(negedge clk);
    expect_lkp("R9 stale dynamic cleared", a, 2'd0, 0, 0, 3'b110, 0);
    expect_lkp("R9 static never aged", mac_in(8'h21, 40'h0A00000001), 2'd0, 1, 1, 3'b101, 3'd6);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; age_limit = 10'd1023;
    lkp_req = 1'b0; lkp_mac = '0; lkp_in_port = '0;
    lrn_req = 1'b0; lrn_mac = '0; lrn_port = '0;
    hst_req = 1'b0; hst_idx = '0; hst_valid = 1'b0; hst_mac = '0;
    hst_mask = '0; hst_prio = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_latency();
    t_learn_move();
    t_static();
    t_full_static();
    t_collide();
    t_replace();
    t_time();
    t_age();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule